// File: doc/BRIEF.md
# Multichannel PCM Codec Frame-Sync Formatter

This block drives a serial PCM highway shared by up to eighteen voice codecs. From the system clock it derives a bit clock and runs a repeating frame of 8-bit time slots. It sends one transmit byte per channel, most significant bit first, and collects one receive byte per channel from the returning serial line. For every channel whose codec is present it raises that channel's frame-sync output, in slot order. A sync is either a one-bit strobe just ahead of the slot (short style) or a pulse that spans all eight data bits (long style).

The frame holds 24 slots (the slower rate) or 32 slots (the faster rate). Slot k carries channel k+1, and the slots after the last channel are idle. A mode bit turns the six lowest sync outputs into a binary bus. That bus shows the number of the channel currently on the line, so external decode logic can build its own strobes. On the core side each channel has a parallel transmit byte, taken at the start of its slot, and a receive byte with a one-cycle valid pulse when its slot completes.

All configuration inputs (`rate_sel`, `long_fs`, `enc_fs`, `chan_en`) are expected to change only while `rst_n` is low.

Top module: `pcm_sync_fmt`

## Requirements
- R1: `bclk_o` is a square wave with a period of 2*HALF_DIV system clocks. The first rising edge after reset starts slot 0, bit 0. A frame is 192 bit periods when `rate_sel`=0 and 256 when `rate_sel`=1. Bit period p belongs to slot p/8, and slot k carries channel k+1 (`chan_en[k]`, `sync_o[k]`, byte k of `tx_data`/`rx_data` at bits 8k+7..8k).
- R2: For an enabled channel, `tx_o` carries its byte MSB first and changes only with a rising `bclk_o`. The byte is taken from `tx_data` at the rising edge that starts the slot, and later changes to `tx_data` do not affect that slot.
- R3: `tx_o` is low during idle slots and during the slots of disabled channels.
- R4: `rx_i` is sampled at each falling `bclk_o`, MSB first. After the eighth bit of an enabled channel's slot, that channel's byte in `rx_data` holds the eight bits. `rx_valid[k]` is high for exactly the one system clock in which `bclk_o` has just fallen.
- R5: Bits received in idle slots or in slots of disabled channels raise no `rx_valid` and leave `rx_data` unchanged.
- R6: With `long_fs`=0, `sync_o[k]` of an enabled channel is high for exactly the bit period before the first bit of slot k. For channel 1 this is the last bit period of the previous frame.
- R7: With `long_fs`=1, `sync_o[k]` of an enabled channel is high for the eight bit periods of slot k.
- R8: The sync output of a disabled channel stays low for the whole frame.
- R9: With `enc_fs`=1, `sync_o[5:0]` carries n in binary (bit 0 on `sync_o[0]`) during the slot of enabled channel n (1..18), and 0 during every other slot. `sync_o[17:6]` keep their strobe behaviour.
- R10: `sync_o` and `tx_o` change only on a rising `bclk_o`. With `enc_fs`=0, at most one sync output is high at a time.
- R11: While `rst_n` is low, `bclk_o`, `tx_o`, `sync_o`, `rx_valid` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 1 | 0: 24-slot frame, 1: 32-slot frame |
| long_fs | input | 1 | 0: short one-bit sync, 1: slot-long sync |
| enc_fs | input | 1 | 1: low six sync pins carry the channel number |
| chan_en | input | NCH | Codec present on channel k+1 |
| tx_data | input | 8*NCH | Transmit byte per channel |
| rx_i | input | 1 | Serial data from the codecs |
| bclk_o | output | 1 | PCM bit clock |
| tx_o | output | 1 | Serial data to the codecs |
| sync_o | output | NCH | Frame syncs or encoded channel number |
| rx_data | output | 8*NCH | Last received byte per channel |
| rx_valid | output | NCH | One-cycle pulse when a channel's byte arrives |

## Verification
A wrong slot position shows up within one bit period as a sync strobe or bus value in the wrong bit period. The transmit bit is also wrong in that same period. A wrong bit index inside the transmit shift corrupts `tx_o` on the next rising `bclk_o`. A wrong receive shift shows up at the end of the slot as a wrong byte in `rx_data`. A valid pulse sent to the wrong channel, or raised for an idle slot, is caught in the clock where it appears. Because every bit period of each frame is compared against the expected sync and data values, an error at any position is seen in the first frame that reaches it.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;
    localparam int POS_W  = 8;
    localparam int BIT_W  = 3;
    localparam int SLOT_W = POS_W - BIT_W;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [BIT_W-1:0]  bitn_t;

    // last bit position of the frame: 24 or 32 slots of 8 bits
    function automatic pos_t last_pos(input logic rate32);
        return rate32 ? pos_t'(255) : pos_t'(191);
    endfunction

    function automatic slot_t slot_of(input pos_t p);
        return p[POS_W-1:BIT_W];
    endfunction

    function automatic bitn_t bit_of(input pos_t p);
        return p[BIT_W-1:0];
    endfunction
endpackage

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            bclk;
    } tmr_t;

    tmr_t s_d, s_q;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.ph == PH_LAST);
        if (wrap) begin
            s_d.ph   = '0;
            s_d.bclk = ~s_q.bclk;
        end else begin
            s_d.ph = s_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bclk_o = s_q.bclk;
    assign rise_o = wrap & ~s_q.bclk;
    assign fall_o = wrap &  s_q.bclk;
endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq
    import pcm_fmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic rate_sel,
    output pos_t pos_q_o,
    output pos_t pos_nx_o
);
    typedef struct packed {
        pos_t pos;
    } seq_t;

    seq_t s_d, s_q;
    pos_t nxt;

    always_comb begin
        s_d = s_q;
        nxt = (s_q.pos >= last_pos(rate_sel)) ? '0 : s_q.pos + 1'b1;
        if (rise_i) s_d.pos = nxt;
    end

    // reset parks on the top position so the first rise enters position 0
    always_ff @(posedge clk) begin
        if (!rst_n) s_q.pos <= '1;
        else        s_q     <= s_d;
    end

    assign pos_q_o  = s_q.pos;
    assign pos_nx_o = nxt;
endmodule

// File: rtl/pcm_sync_gen.sv
module pcm_sync_gen
    import pcm_fmt_pkg::*;
#(
    parameter int NCH      = 18,
    parameter int ENC_PINS = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rise_i,
    input  pos_t           pos_nx_i,
    input  logic           rate_sel,
    input  logic           long_fs,
    input  logic           enc_fs,
    input  logic [NCH-1:0] chan_en,
    output logic [NCH-1:0] sync_o
);
    localparam slot_t NCH_S = SLOT_W'(NCH);

    typedef struct packed {
        logic [NCH-1:0] sync;
    } sg_t;

    sg_t s_d, s_q;
    logic [NCH-1:0]      strobe_w;
    logic [NCH-1:0]      nxt;
    logic [ENC_PINS-1:0] code;
    slot_t               slot_nx;
    logic                slot_on;

    assign slot_nx = slot_of(pos_nx_i);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit_short;
        if (g == 0) begin : g_first
            // channel 1 is announced in the last bit of the previous frame
            assign hit_short = (pos_nx_i == last_pos(rate_sel));
        end else begin : g_rest
            assign hit_short = (pos_nx_i == POS_W'(g * 8 - 1));
        end
        assign strobe_w[g] = chan_en[g] &
                             (long_fs ? (slot_nx == SLOT_W'(g)) : hit_short);
    end

    always_comb begin
        s_d     = s_q;
        slot_on = (slot_nx < NCH_S) && chan_en[slot_nx];
        code    = slot_on ? ENC_PINS'(slot_nx + 1'b1) : '0;
        nxt     = strobe_w;
        if (enc_fs) nxt[ENC_PINS-1:0] = code;
        if (rise_i) s_d.sync = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.sync;
endmodule

// File: rtl/pcm_data_path.sv
module pcm_data_path
    import pcm_fmt_pkg::*;
#(
    parameter int NCH = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_i,
    input  logic                fall_i,
    input  pos_t                pos_q_i,
    input  pos_t                pos_nx_i,
    input  logic [NCH-1:0]      chan_en,
    input  logic [NCH-1:0][7:0] tx_bytes,
    input  logic                rx_i,
    output logic                tx_o,
    output logic [NCH-1:0][7:0] rx_bytes,
    output logic [NCH-1:0]      rx_valid
);
    localparam slot_t NCH_S = SLOT_W'(NCH);

    typedef struct packed {
        logic [7:0]           txsh;
        logic                 tx;
        logic [6:0]           rsh;
        logic [NCH-1:0][7:0]  rxd;
        logic [NCH-1:0]       vld;
    } dp_t;

    dp_t   s_d, s_q;
    slot_t tslot, rslot;
    bitn_t tbit, rbit;
    logic  t_on, r_on;

    always_comb begin
        s_d     = s_q;
        s_d.vld = '0;
        tslot   = slot_of(pos_nx_i);
        tbit    = bit_of(pos_nx_i);
        rslot   = slot_of(pos_q_i);
        rbit    = bit_of(pos_q_i);
        t_on    = (tslot < NCH_S) && chan_en[tslot];
        r_on    = (rslot < NCH_S) && chan_en[rslot];

        // transmit: advance with the rising bit clock
        if (rise_i) begin
            if (!t_on) begin
                s_d.tx = 1'b0;
            end else if (tbit == '0) begin
                s_d.txsh = tx_bytes[tslot];
                s_d.tx   = tx_bytes[tslot][7];
            end else begin
                s_d.tx = s_q.txsh[3'd7 - tbit];
            end
        end

        // receive: sample with the falling bit clock
        if (fall_i && r_on) begin
            s_d.rsh = {s_q.rsh[5:0], rx_i};
            if (rbit == 3'd7) begin
                s_d.rxd[rslot] = {s_q.rsh, rx_i};
                s_d.vld[rslot] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_o     = s_q.tx;
    assign rx_bytes = s_q.rxd;
    assign rx_valid = s_q.vld;
endmodule

// File: rtl/pcm_sync_fmt.sv
module pcm_sync_fmt
    import pcm_fmt_pkg::*;
#(
    parameter int NCH      = 18,
    parameter int HALF_DIV = 2,
    parameter int ENC_PINS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_sel,
    input  logic             long_fs,
    input  logic             enc_fs,
    input  logic [NCH-1:0]   chan_en,
    input  logic [NCH*8-1:0] tx_data,
    input  logic             rx_i,
    output logic             bclk_o,
    output logic             tx_o,
    output logic [NCH-1:0]   sync_o,
    output logic [NCH*8-1:0] rx_data,
    output logic [NCH-1:0]   rx_valid
);
    logic rise, fall;
    pos_t pos_q, pos_nx;
    logic [NCH-1:0][7:0] tx_bytes, rx_bytes;

    assign tx_bytes = tx_data;
    assign rx_data  = rx_bytes;

    pcm_bit_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
        .clk(clk), .rst_n(rst_n), .bclk_o(bclk_o), .rise_o(rise), .fall_o(fall)
    );

    pcm_slot_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .rate_sel(rate_sel),
        .pos_q_o(pos_q), .pos_nx_o(pos_nx)
    );

    pcm_sync_gen #(.NCH(NCH), .ENC_PINS(ENC_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .pos_nx_i(pos_nx),
        .rate_sel(rate_sel), .long_fs(long_fs), .enc_fs(enc_fs),
        .chan_en(chan_en), .sync_o(sync_o)
    );

    pcm_data_path #(.NCH(NCH)) u_dp (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
        .pos_q_i(pos_q), .pos_nx_i(pos_nx), .chan_en(chan_en),
        .tx_bytes(tx_bytes), .rx_i(rx_i), .tx_o(tx_o),
        .rx_bytes(rx_bytes), .rx_valid(rx_valid)
    );
endmodule

// File: rtl/pcm_fmt_chk.sv
module pcm_fmt_chk #(
    parameter int NCH      = 18,
    parameter int ENC_PINS = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enc_fs,
    input logic [NCH-1:0] chan_en,
    input logic           bclk_o,
    input logic           tx_o,
    input logic [NCH-1:0] sync_o,
    input logic [NCH-1:0] rx_valid
);
    assert_sync_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(bclk_o) |-> $stable(sync_o));

    assert_tx_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(bclk_o) |-> $stable(tx_o));

    assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_fs |-> $onehot0(sync_o));

    assert_absent_sync_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_fs |-> ((sync_o & ~chan_en) == '0));

    assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        enc_fs |-> (sync_o[ENC_PINS-1:0] <= ENC_PINS'(NCH)));

    assert_valid_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid != '0) |-> ($fell(bclk_o) && $onehot0(rx_valid)));

    assert_valid_enabled_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid & ~chan_en) == '0);
endmodule

bind pcm_sync_fmt pcm_fmt_chk #(.NCH(NCH), .ENC_PINS(ENC_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .enc_fs(enc_fs), .chan_en(chan_en),
    .bclk_o(bclk_o), .tx_o(tx_o), .sync_o(sync_o), .rx_valid(rx_valid)
);

// File: tb/tb_pcm_sync_fmt.sv
module tb_pcm_sync_fmt;
    localparam int NCH = 18;
    localparam int HD  = 2;
    localparam int DW  = NCH * 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           rate_sel = 1'b0, long_fs = 1'b0, enc_fs = 1'b0;
    logic [NCH-1:0] chan_en = '0;
    logic [DW-1:0]  tx_v = '0;
    logic           rx_i = 1'b0;
    logic           bclk_o, tx_o;
    logic [NCH-1:0] sync_o, rx_valid;
    logic [DW-1:0]  rx_data;

    pcm_sync_fmt #(.NCH(NCH), .HALF_DIV(HD), .ENC_PINS(6)) dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .long_fs(long_fs),
        .enc_fs(enc_fs), .chan_en(chan_en), .tx_data(tx_v), .rx_i(rx_i),
        .bclk_o(bclk_o), .tx_o(tx_o), .sync_o(sync_o), .rx_data(rx_data),
        .rx_valid(rx_valid)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int vcnt [NCH];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog R1 act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) if (rx_valid[c] === 1'b1) vcnt[c] = vcnt[c] + 1;
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] exp_sync(input int p, input int fl, input logic lng,
                                                 input logic enc, input logic [NCH-1:0] en);
        logic [NCH-1:0] s;
        int sl;
        s  = '0;
        sl = p / 8;
        for (int c = 0; c < NCH; c++) begin
            if (en[c]) begin
                if (lng) s[c] = (sl == c);
                else     s[c] = (p == ((c == 0) ? fl - 1 : c * 8 - 1));
            end
        end
        if (enc) s[5:0] = (sl < NCH && en[sl]) ? 6'(sl + 1) : 6'd0;
        return s;
    endfunction

    task automatic run_cfg(input logic rt, input logic lng, input logic enc,
                           input logic [NCH-1:0] en, input int frames);
        int fl, last_c, ev [NCH];
        logic prev_b, hit;
        logic [7:0] lat [NCH];
        logic [7:0] rxb;
        logic [DW-1:0] exp_rx;
        logic [NCH-1:0] s_prev;
        logic t_prev;
        string stag;

        rst_n = 1'b0;
        rate_sel = rt; long_fs = lng; enc_fs = enc; chan_en = en;
        for (int c = 0; c < NCH; c++) begin
            tx_v[c*8 +: 8] = 8'($urandom);
            lat[c] = '0;
            ev[c] = 0;
        end
        rx_i = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 sync", DW'(sync_o), '0);
        check("R11 tx/bclk/valid", DW'({tx_o, bclk_o, rx_valid}), '0);
        check("R11 rx_data", rx_data, '0);
        for (int c = 0; c < NCH; c++) vcnt[c] = 0;
        rst_n  = 1'b1;
        exp_rx = '0;
        fl     = rt ? 256 : 192;
        prev_b = 1'b0;
        last_c = 0;
        rxb    = '0;
        stag   = enc ? "R9 R8" : (lng ? "R7 R8" : "R6 R8");

        for (int k = 0; k < frames * fl; k++) begin
            int p, sl, b;
            hit = 1'b0;
            while (!hit) begin
                @(negedge clk);
                hit    = bclk_o && !prev_b;
                prev_b = bclk_o;
            end
            p  = k % fl;
            sl = p / 8;
            b  = p % 8;
            if (k > 0) check("R1 bit period", DW'(cyc - last_c), DW'(2 * HD));
            last_c = cyc;

            if (b == 0 && k > 0) begin
                int ps;
                ps = ((p + fl - 1) % fl) / 8;
                if (ps < NCH && en[ps]) begin
                    exp_rx[ps*8 +: 8] = rxb;
                    ev[ps] = ev[ps] + 1;
                end
                check("R4 R5 rx_data", rx_data, exp_rx);
            end

            if (b == 0 && sl < NCH) lat[sl] = tx_v[sl*8 +: 8];
            if (sl < NCH && en[sl]) check("R2 tx bit", DW'(tx_o), DW'(lat[sl][7-b]));
            else                    check("R3 tx idle", DW'(tx_o), '0);

            check(stag, DW'(sync_o), DW'(exp_sync(p, fl, lng, enc, en)));

            if (b == 0) rxb = 8'($urandom);
            rx_i = rxb[7-b];
            if (b == 3) begin
                // R2: mid-slot change must not reach the line
                for (int c = 0; c < NCH; c++) tx_v[c*8 +: 8] = 8'($urandom);
            end

            s_prev = sync_o;
            t_prev = tx_o;
            repeat (HD) @(negedge clk);
            prev_b = bclk_o;
            check("R10 stable mid-bit", DW'({s_prev, t_prev}), DW'({sync_o, tx_o}));
        end
        repeat (2 * HD + 2) @(negedge clk);
        for (int c = 0; c < NCH; c++) check("R4 R5 valid count", DW'(vcnt[c]), DW'(ev[c]));
    endtask

    initial begin
        void'($urandom(32'd1234));
        run_cfg(1'b0, 1'b0, 1'b0, {NCH{1'b1}}, 2);
        run_cfg(1'b1, 1'b1, 1'b0, {NCH{1'b1}}, 2);
        run_cfg(1'b1, 1'b0, 1'b0, 18'h20001, 2);
        run_cfg(1'b0, 1'b1, 1'b1, '0, 1);
        run_cfg(1'b0, 1'b0, 1'b1, {NCH{1'b1}}, 2);
        for (int r = 0; r < 4; r++) begin
            run_cfg(1'($urandom), 1'($urandom), 1'($urandom), NCH'($urandom), 2);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule